// File: doc/BRIEF.md
# Request/Reply Queue Port with Interrupt Status

This block sits between a host register bus and the command engine of a storage controller. The host posts the 32-bit address of a request frame by writing the request queue register. The block keeps these addresses in a FIFO and offers the oldest one to a downstream consumer through a valid/ready handshake. A completion source returns results as reply words, and the block queues them in a reply FIFO that the host drains by reading the reply queue register.

A reply word takes one of two forms, and bit 31 tells them apart. With bit 31 clear, the word carries the message context of a request that completed successfully. With bit 31 set, the word is an address reply and points at a full reply frame. Address replies draw their frame from a free list. The host refills that free list by writing frame addresses to the reply queue register, the same offset it reads replies from.

A status register shows whether replies are pending and mirrors two doorbell inputs. A mask register gates both interrupt sources onto one interrupt output.

Top module: `mq_port`

## Requirements
- R1: After reset, both queues and the free list are empty. `irq`, `rq_valid` and `req_ovf` are low, the status register (offset 0x30) reads 0 when both doorbell inputs are low, and the mask register (offset 0x34) reads 0x0000_0009.
- R2: A host write to offset 0x40 appends the written word to a request FIFO of REQ_DEPTH entries. `rq_valid` is high while that FIFO holds an entry, and `rq_addr` shows the oldest entry. An entry leaves the FIFO in a cycle where `rq_valid` and `rq_ready` are both high. While `rq_ready` is low, `rq_addr` holds its value.
- R3: A write to offset 0x40 while the request FIFO is full is dropped and sets `req_ovf`. `req_ovf` stays high until reset.
- R4: A host read of offset 0x44 removes the oldest reply word and returns it on `reg_rdata` in the cycle after the read strobe. Replies come out in the order they were accepted.
- R5: A read of offset 0x44 while the reply FIFO is empty returns 0xFFFF_FFFF and changes no state.
- R6: An accepted completion with `cpl_is_addr` low queues the word {1'b0, cpl_ctx[30:0]}.
- R7: A completion with `cpl_is_addr` high is accepted only while the free list holds an entry, and `cpl_ready` is low otherwise. When accepted, it takes the oldest free-frame address A off the free list and queues {1'b1, A[31:1]}.
- R8: A host write to offset 0x44 appends the written address to a free list of FREE_DEPTH entries. A write while the free list is full is dropped.
- R9: The status register at offset 0x30 reads bit 3 = reply FIFO not empty, bit 31 = `db_status`, bit 0 = `db_event`, and all other bits 0. Writes to it have no effect.
- R10: In the mask register at offset 0x34, only bit 0 (doorbell mask) and bit 3 (reply mask) can be written. All other bits read 0.
- R11: `irq` = (status bit 3 AND NOT mask bit 3) OR (status bit 0 AND NOT mask bit 0).
- R12: `cpl_ready` is low while the reply FIFO holds RPL_DEPTH words, and no completion is accepted then.
- R13: A read of offset 0x40, or of any offset not named above, returns 0. A write to an offset not named above changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | ADDR_W | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid the cycle after `reg_rd` |
| rq_valid | output | 1 | A request frame address is available |
| rq_ready | input | 1 | Consumer takes the request address |
| rq_addr | output | 32 | Oldest request frame address |
| cpl_valid | input | 1 | Completion offered |
| cpl_is_addr | input | 1 | Completion needs a full reply frame |
| cpl_ctx | input | 31 | Message context of a successful completion |
| cpl_ready | output | 1 | Completion accepted this cycle |
| db_status | input | 1 | Doorbell busy state, shown in status bit 31 |
| db_event | input | 1 | Doorbell interrupt source, shown in status bit 0 |
| irq | output | 1 | Masked interrupt output |
| req_ovf | output | 1 | Sticky request queue overflow flag |

## Verification
The bench uses the default parameters: a 16-entry request FIFO, an 8-entry reply FIFO and a 4-entry free list. These sizes are small enough that directed tests can reach every full condition in a few dozen cycles. They include the dropped 17th request write, the refused 9th completion, the dropped 5th free-frame write, and the address reply refused once the list has run dry. The bench checks the two reply encodings, the all-ones result of reading an empty queue, and the interrupt output under each mask setting against values it computes from the requirements.

// File: rtl/mq_pkg.sv
package mq_pkg;

    localparam int unsigned WORD_W = 32;

    localparam logic [7:0] OFS_STAT = 8'h30;
    localparam logic [7:0] OFS_MASK = 8'h34;
    localparam logic [7:0] OFS_REQ  = 8'h40;
    localparam logic [7:0] OFS_RPL  = 8'h44;

    localparam int unsigned BIT_DB_EVT  = 0;
    localparam int unsigned BIT_RPL     = 3;
    localparam int unsigned BIT_DB_STAT = 31;

    localparam logic [WORD_W-1:0] MASK_WRITABLE = 32'h0000_0009;
    localparam logic [WORD_W-1:0] MASK_RESET    = 32'h0000_0009;
    localparam logic [WORD_W-1:0] EMPTY_WORD    = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_REQ,
        SEL_RPL
    } reg_sel_e;

    typedef struct packed {
        logic        is_frame;
        logic [30:0] payload;
    } reply_word_t;

    function automatic reply_word_t make_ctx_word(input logic [30:0] ctx);
        reply_word_t w;
        w.is_frame = 1'b0;
        w.payload  = ctx;
        return w;
    endfunction

    function automatic reply_word_t make_frame_word(input logic [WORD_W-1:0] frame);
        reply_word_t w;
        w.is_frame = 1'b1;
        w.payload  = frame[WORD_W-1:1];
        return w;
    endfunction

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_STAT: s = SEL_STAT;
            OFS_MASK: s = SEL_MASK;
            OFS_REQ:  s = SEL_REQ;
            OFS_RPL:  s = SEL_RPL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/mq_reply_gen.sv
module mq_reply_gen
    import mq_pkg::*;
(
    input  logic              cpl_valid,
    input  logic              cpl_is_addr,
    input  logic [30:0]       cpl_ctx,
    input  logic              free_empty,
    input  logic [WORD_W-1:0] free_head,
    input  logic              rpl_full,
    output logic              cpl_ready,
    output logic              rpl_push,
    output reply_word_t       rpl_word,
    output logic              free_pop
);
    logic frame_ok;

    always_comb begin
        frame_ok  = !cpl_is_addr || !free_empty;
        cpl_ready = !rpl_full && frame_ok;
        rpl_push  = cpl_valid && cpl_ready;
        free_pop  = rpl_push && cpl_is_addr;
        if (cpl_is_addr) begin
            rpl_word = make_frame_word(free_head);
        end else begin
            rpl_word = make_ctx_word(cpl_ctx);
        end
    end

endmodule

// File: rtl/mq_csr.sv
module mq_csr
    import mq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              req_full,
    output logic              req_push,
    input  logic              rpl_empty,
    input  logic [WORD_W-1:0] rpl_head,
    output logic              rpl_pop,
    output logic              free_push,
    input  logic              db_status,
    input  logic              db_event,
    output logic              irq,
    output logic              req_ovf,
    output logic [WORD_W-1:0] mask_q
);
    reg_sel_e          sel;
    logic [WORD_W-1:0] stat_v;
    logic [WORD_W-1:0] rd_mux;

    always_comb begin
        if (reg_addr > ADDR_W'(8'hFF)) begin
            sel = SEL_NONE;
        end else begin
            sel = decode_ofs(8'(reg_addr));
        end
    end

    assign req_push  = reg_wr && (sel == SEL_REQ);
    assign free_push = reg_wr && (sel == SEL_RPL);
    assign rpl_pop   = reg_rd && (sel == SEL_RPL);

    always_comb begin
        stat_v              = '0;
        stat_v[BIT_RPL]     = !rpl_empty;
        stat_v[BIT_DB_EVT]  = db_event;
        stat_v[BIT_DB_STAT] = db_status;
    end

    assign irq = (stat_v[BIT_RPL] && !mask_q[BIT_RPL]) ||
                 (stat_v[BIT_DB_EVT] && !mask_q[BIT_DB_EVT]);

    always_comb begin
        case (sel)
            SEL_STAT: rd_mux = stat_v;
            SEL_MASK: rd_mux = mask_q;
            SEL_RPL:  rd_mux = rpl_empty ? EMPTY_WORD : rpl_head;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= MASK_RESET;
            req_ovf   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            if (reg_wr && (sel == SEL_MASK)) begin
                mask_q <= reg_wdata & MASK_WRITABLE;
            end
            if (req_push && req_full) begin
                req_ovf <= 1'b1;
            end
            if (reg_rd) begin
                reg_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/mq_port.sv
module mq_port
    import mq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned REQ_DEPTH  = 16,
    parameter int unsigned RPL_DEPTH  = 8,
    parameter int unsigned FREE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rq_valid,
    input  logic              rq_ready,
    output logic [31:0]       rq_addr,
    input  logic              cpl_valid,
    input  logic              cpl_is_addr,
    input  logic [30:0]       cpl_ctx,
    output logic              cpl_ready,
    input  logic              db_status,
    input  logic              db_event,
    output logic              irq,
    output logic              req_ovf
);
    logic              req_push, req_full, req_empty;
    logic              rpl_push, rpl_pop, rpl_full, rpl_empty;
    logic [WORD_W-1:0] rpl_head;
    reply_word_t       rpl_word;
    logic              free_push, free_pop, free_full, free_empty;
    logic [WORD_W-1:0] free_head;
    logic [WORD_W-1:0] mask_q;

    mq_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_full  (req_full),
        .req_push  (req_push),
        .rpl_empty (rpl_empty),
        .rpl_head  (rpl_head),
        .rpl_pop   (rpl_pop),
        .free_push (free_push),
        .db_status (db_status),
        .db_event  (db_event),
        .irq       (irq),
        .req_ovf   (req_ovf),
        .mask_q    (mask_q)
    );

    mq_fifo #(.WIDTH(WORD_W), .DEPTH(REQ_DEPTH)) u_req_q (
        .clk   (clk),
        .rst   (rst),
        .push  (req_push),
        .wdata (reg_wdata),
        .pop   (rq_valid && rq_ready),
        .head  (rq_addr),
        .full  (req_full),
        .empty (req_empty)
    );

    assign rq_valid = !req_empty;

    mq_fifo #(.WIDTH(WORD_W), .DEPTH(FREE_DEPTH)) u_free_q (
        .clk   (clk),
        .rst   (rst),
        .push  (free_push),
        .wdata (reg_wdata),
        .pop   (free_pop),
        .head  (free_head),
        .full  (free_full),
        .empty (free_empty)
    );

    mq_reply_gen u_gen (
        .cpl_valid   (cpl_valid),
        .cpl_is_addr (cpl_is_addr),
        .cpl_ctx     (cpl_ctx),
        .free_empty  (free_empty),
        .free_head   (free_head),
        .rpl_full    (rpl_full),
        .cpl_ready   (cpl_ready),
        .rpl_push    (rpl_push),
        .rpl_word    (rpl_word),
        .free_pop    (free_pop)
    );

    mq_fifo #(.WIDTH(WORD_W), .DEPTH(RPL_DEPTH)) u_rpl_q (
        .clk   (clk),
        .rst   (rst),
        .push  (rpl_push),
        .wdata (rpl_word),
        .pop   (rpl_pop),
        .head  (rpl_head),
        .full  (rpl_full),
        .empty (rpl_empty)
    );

endmodule

// File: rtl/mq_port_chk.sv
module mq_port_chk
    import mq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              rq_valid,
    input logic              rq_ready,
    input logic [31:0]       rq_addr,
    input logic              cpl_valid,
    input logic              cpl_is_addr,
    input logic              cpl_ready,
    input logic              db_event,
    input logic              irq,
    input logic              req_ovf,
    input logic              rpl_empty,
    input logic              free_empty,
    input logic              req_full,
    input logic [31:0]       mask_q
);
    // R5: popping an empty reply queue yields all ones
    a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
        reg_rd && (reg_addr == ADDR_W'(OFS_RPL)) && rpl_empty |=> reg_rdata == EMPTY_WORD);

    // R3: write into a full request queue raises the flag
    a_r3_overflow_set: assert property (@(posedge clk) disable iff (rst)
        reg_wr && (reg_addr == ADDR_W'(OFS_REQ)) && req_full |=> req_ovf);

    // R3: the flag is sticky
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        req_ovf |=> req_ovf);

    // R2: offered request holds while not taken
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr));

    // R7: no address reply without a free frame
    a_r7_no_frame: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && cpl_is_addr && free_empty |-> !cpl_ready);

    // R11: unmasked pending replies raise the interrupt
    a_r11_irq_on: assert property (@(posedge clk) disable iff (rst)
        !rpl_empty && !mask_q[BIT_RPL] |-> irq);

    // R11: no source unmasked, no interrupt
    a_r11_irq_off: assert property (@(posedge clk) disable iff (rst)
        (rpl_empty || mask_q[BIT_RPL]) && (!db_event || mask_q[BIT_DB_EVT]) |-> !irq);

endmodule

bind mq_port mq_port_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .rq_valid    (rq_valid),
    .rq_ready    (rq_ready),
    .rq_addr     (rq_addr),
    .cpl_valid   (cpl_valid),
    .cpl_is_addr (cpl_is_addr),
    .cpl_ready   (cpl_ready),
    .db_event    (db_event),
    .irq         (irq),
    .req_ovf     (req_ovf),
    .rpl_empty   (rpl_empty),
    .free_empty  (free_empty),
    .req_full    (req_full),
    .mask_q      (mask_q)
);

// File: tb/test_mq_port.sv
module test_mq_port;

    localparam int REQ_D  = 16;
    localparam int RPL_D  = 8;
    localparam int FREE_D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rq_valid, rq_ready = 1'b0;
    logic [31:0] rq_addr;
    logic        cpl_valid = 1'b0, cpl_is_addr = 1'b0;
    logic [30:0] cpl_ctx = '0;
    logic        cpl_ready;
    logic        db_status = 1'b0, db_event = 1'b0;
    logic        irq, req_ovf;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mq_port i_mq_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
        .cpl_valid(cpl_valid), .cpl_is_addr(cpl_is_addr), .cpl_ctx(cpl_ctx),
        .cpl_ready(cpl_ready), .db_status(db_status), .db_event(db_event),
        .irq(irq), .req_ovf(req_ovf)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic cpl(input logic is_addr, input logic [30:0] ctx, output logic acc);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_is_addr = is_addr; cpl_ctx = ctx;
        #1 acc = cpl_ready;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", 32'(irq), 0);
        check("R1 rq_valid", 32'(rq_valid), 0);
        check("R1 req_ovf", 32'(req_ovf), 0);
        rd(8'h30, d); check("R1 status", d, 32'h0);
        rd(8'h34, d); check("R1 R10 mask reset", d, 32'h9);
        rd(8'h44, d); check("R1 reply empty", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_request();
        logic [31:0] d;
        int seen;
        wr(8'h40, 32'hA000_0100);
        wr(8'h40, 32'hA000_0200);
        check("R2 valid", 32'(rq_valid), 1);
        check("R2 head", rq_addr, 32'hA000_0100);
        repeat (3) @(negedge clk);
        check("R2 hold", rq_addr, 32'hA000_0100);
        rq_ready = 1'b1;
        @(negedge clk);
        rq_ready = 1'b0;
        check("R2 next", rq_addr, 32'hA000_0200);
        rq_ready = 1'b1;
        @(negedge clk);
        rq_ready = 1'b0;
        check("R2 drained", 32'(rq_valid), 0);
        rd(8'h40, d); check("R13 request read", d, 32'h0);
        for (int i = 0; i < REQ_D + 1; i++) wr(8'h40, 32'h100 + 32'(i));
        check("R3 overflow flag", 32'(req_ovf), 1);
        seen = 0;
        rq_ready = 1'b1;
        for (int i = 0; i < REQ_D + 4; i++) begin
            #1;
            if (rq_valid) begin
                check("R3 order", rq_addr, 32'h100 + 32'(seen));
                seen++;
            end
            @(negedge clk);
        end
        rq_ready = 1'b0;
        check("R3 kept entries", 32'(seen), 32'(REQ_D));
        check("R3 flag sticky", 32'(req_ovf), 1);
    endtask

    task automatic t_context();
        logic [31:0] d;
        logic acc;
        cpl(1'b0, 31'h0000_CAFE, acc); check("R6 accepted", 32'(acc), 1);
        cpl(1'b0, 31'h7FFF_FFFF, acc);
        rd(8'h30, d); check("R9 pending bit", d, 32'h8);
        rd(8'h44, d); check("R4 R6 first", d, 32'h0000_CAFE);
        rd(8'h44, d); check("R4 R6 second", d, 32'h7FFF_FFFF);
        rd(8'h44, d); check("R5 empty pop", d, 32'hFFFF_FFFF);
        rd(8'h44, d); check("R5 repeat empty", d, 32'hFFFF_FFFF);
        rd(8'h30, d); check("R9 pending clear", d, 32'h0);
    endtask

    task automatic t_frames();
        logic [31:0] d;
        logic acc;
        logic [31:0] fr [5];
        fr[0] = 32'h0001_1000; fr[1] = 32'h0002_2002; fr[2] = 32'hFFFF_FFF0;
        fr[3] = 32'h0000_0042; fr[4] = 32'h1234_5678;
        cpl(1'b1, 31'h0, acc); check("R7 refused without frame", 32'(acc), 0);
        rd(8'h44, d); check("R7 nothing queued", d, 32'hFFFF_FFFF);
        for (int i = 0; i < 5; i++) wr(8'h44, fr[i]);
        for (int i = 0; i < 4; i++) begin
            cpl(1'b1, 31'h0, acc); check("R8 frame accepted", 32'(acc), 1);
        end
        cpl(1'b1, 31'h0, acc); check("R8 fifth frame dropped", 32'(acc), 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'h44, d); check("R7 frame word", d, {1'b1, fr[i][31:1]});
        end
        rd(8'h44, d); check("R7 list used up", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_full();
        logic [31:0] d;
        logic acc;
        for (int i = 0; i < RPL_D; i++) cpl(1'b0, 31'(i + 5), acc);
        cpl(1'b0, 31'h77, acc); check("R12 full refuses", 32'(acc), 0);
        for (int i = 0; i < RPL_D; i++) begin
            rd(8'h44, d); check("R12 kept", d, 32'(i + 5));
        end
        rd(8'h44, d); check("R12 extra not queued", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        logic acc;
        cpl(1'b0, 31'h1, acc);
        #1 check("R11 masked reply", 32'(irq), 0);
        wr(8'h34, 32'h0);
        #1 check("R11 unmasked reply", 32'(irq), 1);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, d); check("R10 writable bits", d, 32'h9);
        check("R11 remasked", 32'(irq), 0);
        rd(8'h44, d);
        db_event = 1'b1; db_status = 1'b1;
        rd(8'h30, d); check("R9 doorbell bits", d, 32'h8000_0001);
        check("R11 doorbell masked", 32'(irq), 0);
        wr(8'h34, 32'h8);
        #1 check("R11 doorbell unmasked", 32'(irq), 1);
        wr(8'h30, 32'h0);
        rd(8'h30, d); check("R9 write ignored", d, 32'h8000_0001);
        db_event = 1'b0; db_status = 1'b0;
        wr(8'h20, 32'h0);
        rd(8'h34, d); check("R13 stray write", d, 32'h8);
        rd(8'h20, d); check("R13 stray read", d, 32'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_request();
                t_context();
                t_frames();
                t_full();
                t_irq();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule